// File: doc/BRIEF.md
# Legacy DMA Channel Register File

This block holds the host-visible registers of a four-channel DMA controller in the older personal-computer style. The host reaches every register through 8-bit I/O ports. Each channel keeps a 16-bit transfer address and a 16-bit transfer count. Each of these exists as a base copy and a current copy. Because the ports are only one byte wide, a 16-bit value is moved as two accesses to the same port. A single byte-pointer flag, shared by all channels and both register kinds, decides whether an access hits the low byte or the high byte. A separate command port puts that flag back to the low byte.

Two further command ports act on one channel at a time. The channel is picked by the two low data bits. One port sets or clears that channel's mask. The other stores the remaining six data bits as that channel's mode. The current address, current count, mode and mask of every channel are presented as registered outputs to a transfer engine. The engine can advance a channel one transfer at a time, or copy the base values back into the current ones.

The parameter `WORD_SPACING` doubles every port offset, so one instance of the block can serve as the second controller, whose ports sit only at even addresses. Read data is registered and appears the cycle after the read strobe.

Top module: `dma_regif`

## Requirements
- R1: After reset every channel is masked (`chan_mask` = 4'hF), every address, count and mode output is zero, `io_rdata` is zero, and the byte pointer selects the low byte.
- R2: With byte spacing, channel n's address port is at offset 2n and its count port at 2n+1. Two successive writes to one of these ports load bits 7:0 and then bits 15:8, into both the base copy and the current copy.
- R3: The byte pointer is one flag shared by all eight address and count ports. Every read or write of any of these ports toggles it, so a write to a different port after an odd number of accesses lands in that port's high byte.
- R4: A write of any data to the clear port (offset 12) returns the byte pointer to the low byte.
- R5: A read of an address or count port returns the selected byte of the live current value on `io_rdata` one cycle after the strobe: the low byte first, then the high byte.
- R6: A write to the mask port (offset 10) affects only the channel in data bits 1:0. It masks that channel when bit 2 is 1 and unmasks it when bit 2 is 0. Bits 7:3 are ignored.
- R7: A write to the mode port (offset 11) stores data bits 7:2 as the 6-bit mode of the channel in data bits 1:0. Other channels keep their mode.
- R8: The count holds the number of transfers minus one. An `eng_step` pulse on a channel increments its current address and decrements its current count, so a count of 0x0000 wraps to 0xFFFF after its single transfer.
- R9: An `eng_reload` pulse copies a channel's base address and base count into its current registers.
- R10: With `WORD_SPACING`=1, every offset is doubled and odd port addresses decode to nothing.
- R11: An access to an unmapped port changes no register and leaves the byte pointer alone. A read of an unmapped or write-only port returns 0x00.
- R12: A host write to a channel register takes precedence over `eng_reload` and `eng_step` on that channel in the same cycle. `eng_reload` takes precedence over `eng_step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_port | input | 5 | Port address of the host access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after `io_rd` |
| eng_step | input | 4 | Per channel: advance one transfer |
| eng_reload | input | 4 | Per channel: copy base values into current values |
| chan_addr | output | 64 | Current address, channel n in bits 16n+15:16n |
| chan_count | output | 64 | Current count, channel n in bits 16n+15:16n |
| chan_mode | output | 24 | Mode, channel n in bits 6n+5:6n |
| chan_mask | output | 4 | Mask per channel, 1 = masked |

## Verification
The assertions assume the host never raises `io_rd` and `io_wr` in the same cycle. They also assume the strobes are only ever high for a single cycle per byte. The bench drives every access through one task that raises exactly one strobe for one cycle and then drops it. The engine inputs are pulsed the same way, and never at the same time as a host write to the same channel. The one exception is a dedicated precedence test, which checks the outcome at the ports rather than through assertions.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int CH_NUM   = 4;
  localparam int CH_SEL_W = 2;
  localparam int BYTE_W   = 8;
  localparam int MODE_W   = BYTE_W - CH_SEL_W;
  localparam int OFF_W    = 4;
  localparam logic [OFF_W-1:0] OFF_MASK  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE  = 4'hB;
  localparam logic [OFF_W-1:0] OFF_CLRFF = 4'hC;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_ADDR, ACC_CNT, ACC_MASK, ACC_MODE, ACC_CLRFF
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e             kind;
    logic [CH_SEL_W-1:0]   ch;
  } port_hit_t;
endpackage

// File: rtl/dma_port_dec.sv
module dma_port_dec
  import dma_regif_pkg::*;
#(
  parameter int PORT_W       = 5,
  parameter bit WORD_SPACING = 1'b0
) (
  input  logic [PORT_W-1:0] port,
  output port_hit_t         hit
);
  localparam int SHIFT = WORD_SPACING ? 1 : 0;

  logic [PORT_W-1:0] scaled;
  logic [OFF_W-1:0]  off;
  logic              aligned;
  logic              in_range;

  assign scaled   = port >> SHIFT;
  assign off      = scaled[OFF_W-1:0];
  assign in_range = ((scaled >> OFF_W) == '0);

  generate
    if (WORD_SPACING) begin : g_word
      assign aligned = ~port[0];
    end else begin : g_byte
      assign aligned = 1'b1;
    end
  endgenerate

  always_comb begin
    hit.kind = ACC_NONE;
    hit.ch   = off[CH_SEL_W:1];
    if (aligned && in_range) begin
      if (!off[OFF_W-1]) begin
        hit.kind = off[0] ? ACC_CNT : ACC_ADDR;
      end else begin
        unique case (off)
          OFF_MASK:  hit.kind = ACC_MASK;
          OFF_MODE:  hit.kind = ACC_MODE;
          OFF_CLRFF: hit.kind = ACC_CLRFF;
          default:   hit.kind = ACC_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              hi_byte,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              step,
  input  logic              reload,
  output logic [DATA_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_cnt
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] base_addr, base_cnt;

  function automatic logic [DATA_W-1:0] merge_byte(
    input logic [DATA_W-1:0] old, input logic hi, input logic [BYTE_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = old;
    if (hi) r[DATA_W-1:BYTE_W] = b[HI_W-1:0];
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (wr_addr) begin
      base_addr <= merge_byte(base_addr, hi_byte, wdata);
      cur_addr  <= merge_byte(base_addr, hi_byte, wdata);
    end else if (reload) begin
      cur_addr  <= base_addr;
    end else if (step) begin
      cur_addr  <= cur_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
    end else if (wr_cnt) begin
      base_cnt <= merge_byte(base_cnt, hi_byte, wdata);
      cur_cnt  <= merge_byte(base_cnt, hi_byte, wdata);
    end else if (reload) begin
      cur_cnt  <= base_cnt;
    end else if (step) begin
      cur_cnt  <= cur_cnt - 1'b1;
    end
  end

  AST_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !wr_cnt) |=> (cur_cnt == $past(cur_cnt) - 1'b1)); // R8

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !wr_addr) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R8

  AST_RELOAD_CNT: assert property (@(posedge clk) disable iff (rst)
    (reload && !wr_cnt) |=> (cur_cnt == base_cnt)); // R9
endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
  import dma_regif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_mask,
  input  logic                     wr_mode,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [CH_NUM-1:0]        mask,
  output logic [CH_NUM*MODE_W-1:0] mode
);
  logic [CH_SEL_W-1:0] sel;
  assign sel = wdata[CH_SEL_W-1:0];

  generate
    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          mask[c] <= 1'b1;
        end else if (wr_mask && sel == CH_SEL_W'(c)) begin
          mask[c] <= wdata[CH_SEL_W];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mode[c*MODE_W +: MODE_W] <= '0;
        end else if (wr_mode && sel == CH_SEL_W'(c)) begin
          mode[c*MODE_W +: MODE_W] <= wdata[BYTE_W-1:CH_SEL_W];
        end
      end
    end
  endgenerate

  AST_MASK_ONE_CH: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> ($countones(mask ^ $past(mask)) <= 1)); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask)); // R6
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int PORT_W       = 5,
  parameter int DATA_W       = 16,
  parameter bit WORD_SPACING = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PORT_W-1:0]        io_port,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [7:0]               io_wdata,
  output logic [7:0]               io_rdata,
  input  logic [3:0]               eng_step,
  input  logic [3:0]               eng_reload,
  output logic [4*DATA_W-1:0]      chan_addr,
  output logic [4*DATA_W-1:0]      chan_count,
  output logic [4*MODE_W-1:0]      chan_mode,
  output logic [3:0]               chan_mask
);
  port_hit_t hit;
  logic      ptr_hi;
  logic      reg_acc;
  logic      clr_wr;

  dma_port_dec #(.PORT_W(PORT_W), .WORD_SPACING(WORD_SPACING)) u_dec (
    .port (io_port),
    .hit  (hit)
  );

  assign reg_acc = (io_wr || io_rd) && (hit.kind == ACC_ADDR || hit.kind == ACC_CNT);
  assign clr_wr  = io_wr && (hit.kind == ACC_CLRFF);

  always_ff @(posedge clk) begin
    if (rst)          ptr_hi <= 1'b0;
    else if (clr_wr)  ptr_hi <= 1'b0;
    else if (reg_acc) ptr_hi <= ~ptr_hi;
  end

  logic [DATA_W-1:0] cur_a [CH_NUM];
  logic [DATA_W-1:0] cur_c [CH_NUM];

  generate
    for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
      logic ch_hit;
      assign ch_hit = io_wr && (hit.ch == CH_SEL_W'(c));
      dma_chan_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_addr  (ch_hit && hit.kind == ACC_ADDR),
        .wr_cnt   (ch_hit && hit.kind == ACC_CNT),
        .hi_byte  (ptr_hi),
        .wdata    (io_wdata),
        .step     (eng_step[c]),
        .reload   (eng_reload[c]),
        .cur_addr (cur_a[c]),
        .cur_cnt  (cur_c[c])
      );
      assign chan_addr[c*DATA_W +: DATA_W]  = cur_a[c];
      assign chan_count[c*DATA_W +: DATA_W] = cur_c[c];
    end
  endgenerate

  dma_cmd_regs u_cmd (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (io_wr && hit.kind == ACC_MASK),
    .wr_mode (io_wr && hit.kind == ACC_MODE),
    .wdata   (io_wdata),
    .mask    (chan_mask),
    .mode    (chan_mode)
  );

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = (hit.kind == ACC_CNT) ? cur_c[hit.ch] : cur_a[hit.ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd && reg_acc) begin
      io_rdata <= ptr_hi ? rd_word[DATA_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    end else begin
      io_rdata <= '0;
    end
  end

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    reg_acc |=> (ptr_hi != $past(ptr_hi))); // R3

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !ptr_hi); // R4

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (io_rd && hit.kind == ACC_NONE) |=> (io_rdata == 8'h00)); // R11

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!reg_acc && !clr_wr) |=> $stable(ptr_hi)); // R11

  AST_RESET_MASKED: assert property (@(posedge clk)
    $past(rst) |-> (chan_mask == 4'hF)); // R1
endmodule

// File: tb/sim_dma_regif.sv
module sim_dma_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  io_port = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [3:0]  eng_step = '0, eng_reload = '0;
  logic [7:0]  rdata0, rdata1;
  logic [63:0] addr0, cnt0, addr1, cnt1;
  logic [23:0] mode0, mode1;
  logic [3:0]  mask0, mask1;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_regif u0 (
    .clk(clk), .rst(rst), .io_port(io_port), .io_wr(bus_wr && !bus_sel),
    .io_rd(bus_rd && !bus_sel), .io_wdata(io_wdata), .io_rdata(rdata0),
    .eng_step(eng_step), .eng_reload(eng_reload), .chan_addr(addr0),
    .chan_count(cnt0), .chan_mode(mode0), .chan_mask(mask0));

  dma_regif #(.WORD_SPACING(1'b1)) u1 (
    .clk(clk), .rst(rst), .io_port(io_port), .io_wr(bus_wr && bus_sel),
    .io_rd(bus_rd && bus_sel), .io_wdata(io_wdata), .io_rdata(rdata1),
    .eng_step(4'h0), .eng_reload(4'h0), .chan_addr(addr1),
    .chan_count(cnt1), .chan_mode(mode1), .chan_mask(mask1));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] p, input logic [7:0] d);
    @(negedge clk); io_port = p; io_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] p, output logic [7:0] d);
    @(negedge clk); io_port = p; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    d = bus_sel ? rdata1 : rdata0;
  endtask

  task automatic pulse_step(input logic [3:0] m);
    @(negedge clk); eng_step = m;
    @(negedge clk); eng_step = '0;
  endtask

  task automatic pulse_reload(input logic [3:0] m);
    @(negedge clk); eng_reload = m;
    @(negedge clk); eng_reload = '0;
  endtask

  task automatic t_reset();
    check("R1 mask", mask0, 4'hF);
    check("R1 addr", addr0, 64'h0);
    check("R1 count", cnt0, 64'h0);
    check("R1 mode", mode0, 24'h0);
    check("R1 rdata", rdata0, 8'h00);
  endtask

  task automatic t_load();
    wr(5'h00, 8'h34); wr(5'h00, 8'h12);            // R1 ptr starts low, R2
    check("R2 ch0 addr", addr0[15:0], 16'h1234);
    wr(5'h05, 8'hFF); wr(5'h05, 8'h00);
    check("R2 ch2 count", cnt0[47:32], 16'h00FF);
  endtask

  task automatic t_shared();
    wr(5'h02, 8'h11); wr(5'h07, 8'h22);            // R3
    check("R3 ch1 addr low", addr0[31:16], 16'h0011);
    check("R3 ch3 count high", cnt0[63:48], 16'h2200);
  endtask

  task automatic t_clear();
    wr(5'h02, 8'h55);                               // ptr now high
    wr(5'h0C, 8'hA5);                               // R4
    wr(5'h02, 8'h66); wr(5'h02, 8'h77);
    check("R4 ch1 addr", addr0[31:16], 16'h7766);
  endtask

  task automatic t_read();
    logic [7:0] d;
    wr(5'h0C, 8'h00);
    rd(5'h00, d); check("R5 read low", d, 8'h34);
    rd(5'h00, d); check("R5 read high", d, 8'h12);
  endtask

  task automatic t_mask();
    wr(5'h0A, 8'h01); check("R6 unmask ch1", mask0, 4'b1101);
    wr(5'h0A, 8'h00); check("R6 unmask ch0", mask0, 4'b1100);
    wr(5'h0A, 8'h04); check("R6 mask ch0", mask0, 4'b1101);
    wr(5'h0A, 8'hFA); check("R6 upper bits ignored", mask0, 4'b1001);
  endtask

  task automatic t_mode();
    wr(5'h0B, 8'h59); check("R7 ch1 mode", mode0, 24'h000580);
    wr(5'h0B, 8'hFE); check("R7 ch2 mode", mode0, 24'h03F580);
  endtask

  task automatic t_step();
    logic [7:0] d;
    wr(5'h0C, 8'h00);
    wr(5'h05, 8'h00); wr(5'h05, 8'h00);
    wr(5'h04, 8'hFE); wr(5'h04, 8'h00);
    pulse_step(4'b0100);
    check("R8 count wrap", cnt0[47:32], 16'hFFFF);
    check("R8 addr inc", addr0[47:32], 16'h00FF);
    pulse_step(4'b0100);
    check("R8 count dec", cnt0[47:32], 16'hFFFE);
    check("R8 addr carry", addr0[47:32], 16'h0100);
    check("R8 ch0 untouched", addr0[15:0], 16'h1234);
    rd(5'h05, d); check("R5 live count low", d, 8'hFE);
    rd(5'h05, d); check("R5 live count high", d, 8'hFF);
  endtask

  task automatic t_reload();
    pulse_reload(4'b0100);
    check("R9 count reload", cnt0[47:32], 16'h0000);
    check("R9 addr reload", addr0[47:32], 16'h00FE);
  endtask

  task automatic t_prio();
    @(negedge clk); io_port = 5'h04; io_wdata = 8'h40; bus_wr = 1'b1;
    eng_step = 4'b0100; eng_reload = 4'b0100;
    @(negedge clk); bus_wr = 1'b0; eng_step = '0; eng_reload = '0;
    check("R12 write wins", addr0[47:32], 16'h0040);
    check("R12 reload over step", cnt0[47:32], 16'h0000);
    wr(5'h0C, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(5'h08, 8'h99); wr(5'h10, 8'h99); wr(5'h0F, 8'h99);
    wr(5'h00, 8'hAB); wr(5'h00, 8'hCD);
    check("R11 ptr untouched", addr0[15:0], 16'hCDAB);
    check("R11 mask untouched", mask0, 4'b1001);
    rd(5'h0A, d); check("R11 write-only read", d, 8'h00);
    rd(5'h09, d); check("R11 unmapped read", d, 8'h00);
  endtask

  task automatic t_word();
    bus_sel = 1'b1;
    wr(5'h02, 8'h10); wr(5'h02, 8'h20);
    check("R10 ch0 count", cnt1[15:0], 16'h2010);
    wr(5'h01, 8'h77);
    wr(5'h04, 8'h33); wr(5'h04, 8'h44);
    check("R10 odd ignored ch1 addr", addr1[31:16], 16'h4433);
    check("R10 odd ignored ch0 addr", addr1[15:0], 16'h0000);
    wr(5'h14, 8'h00); check("R10 mask port", mask1, 4'b1110);
    wr(5'h04, 8'h01); wr(5'h18, 8'h00); wr(5'h04, 8'h02);
    check("R10 clear port", addr1[31:16], 16'h4402);
    bus_sel = 1'b0;
    check("R10 byte unit untouched", mask0, 4'b1001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset(); t_load(); t_shared(); t_clear(); t_read(); t_mask();
    t_mode(); t_step(); t_reload(); t_prio(); t_unmapped(); t_word();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule